// File: doc/BRIEF.md
# Single-Buffer Serial Channel Status Core

This block is the register-side core of a single-buffered asynchronous serial channel. It holds one byte waiting to be transmitted, one byte received from the line, a four-bit character format register, a control register with enables, and a status register of sticky event flags. A byte-wide register bus reads and writes these registers. The serial engines themselves are outside the block: the receiver presents a finished byte with a one-cycle strobe (plus framing and parity error indications), and the transmitter takes the pending byte with a one-cycle strobe.

Software clears a status flag with a two-step handshake: it reads the status register while the flag is 1, then writes a 0 into that bit position. A flag that software never saw set survives any write. The transmit path follows the same rule. Software loads the transmit byte, then clears the transmit-empty flag through the status register, which hands the byte to the transmitter. The transmit-end flag tracks transmit-empty, and turning the transmitter off pins both flags high. Four interrupt-ready levels combine flags with their enables.

Top module: `ustat_core`

## Requirements
- R1: After synchronous reset the status register reads 0x84 (bit 7 transmit-empty and bit 2 transmit-end set), and the control and format registers read 0x00.
- R2: Status bits 7..3 (7 transmit-empty, 6 receive-full, 5 overrun, 4 framing error, 3 parity error) can only be cleared by software. A bit clears only when a status write puts 0 in it and an earlier status read returned it as 1 with no status write in between. Any other write leaves it unchanged.
- R3: Status bit 0 is a plain read/write bit loaded from every status write. Status bit 1 always reads 0.
- R4: When receive is enabled (control bit 4) and receive-full is 0, an arriving byte is stored, receive-full is set, and framing/parity error flags are set from the error inputs that accompany it.
- R5: A byte that arrives while receive-full is 1 is dropped. The stored byte is kept and the overrun flag is set.
- R6: Reading the receive data register (select 4) returns the stored byte and clears receive-full.
- R7: While receive is disabled, arriving bytes are ignored: no flag and no stored byte changes.
- R8: Writing the transmit data register (select 3) clears transmit-end. Transmit-end is never 1 while transmit-empty is 0.
- R9: While transmit enable (control bit 5) is 0, transmit-empty and transmit-end are held at 1, and a status write cannot clear them.
- R10: While transmit-empty is 0, tx_req is high and tx_byte carries the loaded byte. A tx_take pulse then sets transmit-empty and transmit-end and drops tx_req.
- R11: Format register (select 0) bit 0 selects 7 data bits, bit 1 enables parity, bit 2 selects odd parity, and bit 3 selects 2 stop bits. Each bit drives its fmt_* output.
- R12: Interrupt levels are registered. irq_tx_empty is transmit-empty AND control bit 7, irq_rx_full is receive-full AND control bit 6, irq_error is (overrun OR framing OR parity) AND control bit 6, and irq_tx_end is transmit-end AND control bit 2. Control select is 1 and status select is 2.
- R13: An arriving byte is judged against receive-full as it stood at the start of the cycle. A receive data read in the same cycle as an arrival on a full buffer returns the old byte, clears receive-full and sets overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | ADDR_W | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, valid the cycle after reg_rd |
| rx_valid | input | 1 | Receiver delivers a byte this cycle |
| rx_byte | input | 8 | Received byte |
| rx_frame_err | input | 1 | Framing error accompanying rx_valid |
| rx_parity_err | input | 1 | Parity error accompanying rx_valid |
| tx_take | input | 1 | Transmitter takes the pending byte |
| tx_req | output | 1 | A byte is pending for the transmitter |
| tx_byte | output | 8 | Pending transmit byte |
| fmt_data7 | output | 1 | 7 data bits selected |
| fmt_parity_en | output | 1 | Parity enabled |
| fmt_parity_odd | output | 1 | Odd parity selected |
| fmt_stop2 | output | 1 | Two stop bits selected |
| irq_rx_full | output | 1 | Receive-full interrupt level |
| irq_tx_empty | output | 1 | Transmit-empty interrupt level |
| irq_tx_end | output | 1 | Transmit-end interrupt level |
| irq_error | output | 1 | Receive error interrupt level |

## Verification
Byte arrival from the receiver and a software read of the receive data register can happen in the same cycle. When the buffer is already full, the two collide on the receive-full flag. The bench loads one byte, then raises rx_valid with a second byte in the same cycle as the receive data read. It checks that the read returns the first byte, that receive-full ends up clear with overrun set, and that a later arrival is accepted into the freed buffer. The transmitter's take strobe and a status write meet in the same way on transmit-empty. That case is covered by the rule that hardware sets are applied after software clears.

// File: rtl/ustat_pkg.sv
package ustat_pkg;
  localparam int BYTE_W  = 8;
  localparam int FLAG_LO = 3;

  // register selects
  localparam int SEL_FMT  = 0;
  localparam int SEL_CTRL = 1;
  localparam int SEL_STAT = 2;
  localparam int SEL_TXD  = 3;
  localparam int SEL_RXD  = 4;

  // status bit positions
  localparam int ST_TDE  = 7;
  localparam int ST_RDF  = 6;
  localparam int ST_OVR  = 5;
  localparam int ST_FRM  = 4;
  localparam int ST_PAR  = 3;
  localparam int ST_TEND = 2;
  localparam int ST_USR  = 0;

  // control bit positions
  localparam int CT_TIE  = 7;
  localparam int CT_RIE  = 6;
  localparam int CT_TE   = 5;
  localparam int CT_RE   = 4;
  localparam int CT_TEIE = 2;

  localparam logic [BYTE_W-1:0] STAT_RESET = 8'h84;
  localparam logic [BYTE_W-1:0] CTRL_MASK  = 8'hF4;

  typedef struct packed {
    logic stop2;
    logic par_odd;
    logic par_en;
    logic data7;
  } fmt_t;
endpackage

// File: rtl/ustat_cfg_regs.sv
module ustat_cfg_regs
  import ustat_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] sel,
  input  logic [BYTE_W-1:0] wdata,
  output fmt_t              fmt_q,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] ctrl_d,
  output logic [BYTE_W-1:0] txd_q
);
  logic wr_fmt, wr_ctrl, wr_txd;

  assign wr_fmt  = wr_en && (sel == ADDR_W'(SEL_FMT));
  assign wr_ctrl = wr_en && (sel == ADDR_W'(SEL_CTRL));
  assign wr_txd  = wr_en && (sel == ADDR_W'(SEL_TXD));

  assign ctrl_d = wr_ctrl ? (wdata & CTRL_MASK) : ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q  <= '0;
      ctrl_q <= '0;
      txd_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_fmt) fmt_q <= fmt_t'(wdata[3:0]);
      if (wr_txd) txd_q <= wdata;
    end
  end
endmodule

// File: rtl/ustat_rx_hold.sv
module ustat_rx_hold
  import ustat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_en,
  input  logic              full_q,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              accept,
  output logic              overrun,
  output logic [BYTE_W-1:0] buf_q
);
  // arrival is judged against the full flag held at the start of the cycle
  assign accept  = rx_valid && rx_en && !full_q;
  assign overrun = rx_valid && rx_en && full_q;

  always_ff @(posedge clk) begin
    if (rst)         buf_q <= '0;
    else if (accept) buf_q <= rx_byte;
  end
endmodule

// File: rtl/ustat_flags.sv
module ustat_flags
  import ustat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stat,
  input  logic              rd_stat,
  input  logic              rd_rxd,
  input  logic              wr_txd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rx_accept,
  input  logic              rx_overrun,
  input  logic              frm_in,
  input  logic              par_in,
  input  logic              te_next,
  input  logic              tx_take,
  output logic [BYTE_W-1:0] stat_q,
  output logic [BYTE_W-1:0] stat_d
);
  logic [BYTE_W-1:FLAG_LO] seen_q, seen_d, clr;
  logic                    take_ok;

  // clear mask: flag was seen as 1 and is now written as 0
  for (genvar b = FLAG_LO; b < BYTE_W; b++) begin : g_clr
    assign clr[b] = wr_stat && seen_q[b] && !wdata[b];
  end

  assign take_ok = tx_take && !stat_q[ST_TDE];

  always_comb begin
    stat_d = '0;
    // software clears first, hardware sets after
    stat_d[ST_TDE] = (stat_q[ST_TDE] && !clr[ST_TDE]) || take_ok;
    stat_d[ST_RDF] = (stat_q[ST_RDF] && !clr[ST_RDF] && !rd_rxd) || rx_accept;
    stat_d[ST_OVR] = (stat_q[ST_OVR] && !clr[ST_OVR]) || rx_overrun;
    stat_d[ST_FRM] = (stat_q[ST_FRM] && !clr[ST_FRM]) || (rx_accept && frm_in);
    stat_d[ST_PAR] = (stat_q[ST_PAR] && !clr[ST_PAR]) || (rx_accept && par_in);

    stat_d[ST_TEND] = stat_q[ST_TEND];
    if (wr_txd) stat_d[ST_TEND] = 1'b0;
    if (wr_stat && !stat_d[ST_TDE]) stat_d[ST_TEND] = 1'b0;
    if (take_ok) stat_d[ST_TEND] = 1'b1;

    if (!te_next) begin
      stat_d[ST_TDE]  = 1'b1;
      stat_d[ST_TEND] = 1'b1;
    end

    stat_d[ST_USR] = wr_stat ? wdata[ST_USR] : stat_q[ST_USR];
  end

  always_comb begin
    if (wr_stat)      seen_d = seen_q & wdata[BYTE_W-1:FLAG_LO];
    else if (rd_stat) seen_d = seen_q | stat_q[BYTE_W-1:FLAG_LO];
    else              seen_d = seen_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= STAT_RESET;
      seen_q <= '0;
    end else begin
      stat_q <= stat_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/ustat_core.sv
module ustat_core
  import ustat_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  input  logic              tx_take,
  output logic              tx_req,
  output logic [7:0]        tx_byte,
  output logic              fmt_data7,
  output logic              fmt_parity_en,
  output logic              fmt_parity_odd,
  output logic              fmt_stop2,
  output logic              irq_rx_full,
  output logic              irq_tx_empty,
  output logic              irq_tx_end,
  output logic              irq_error
);
  fmt_t              fmt_q;
  logic [BYTE_W-1:0] ctrl_q, ctrl_d, txd_q, stat_q, stat_d, rx_buf_q;
  logic              wr_stat, rd_stat, rd_rxd, wr_txd;
  logic              rx_accept, rx_overrun;
  logic [BYTE_W-1:0] rd_mux;

  assign wr_stat = reg_wr && (reg_sel == ADDR_W'(SEL_STAT));
  assign wr_txd  = reg_wr && (reg_sel == ADDR_W'(SEL_TXD));
  assign rd_stat = reg_rd && !reg_wr && (reg_sel == ADDR_W'(SEL_STAT));
  assign rd_rxd  = reg_rd && (reg_sel == ADDR_W'(SEL_RXD));

  ustat_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .fmt_q(fmt_q), .ctrl_q(ctrl_q), .ctrl_d(ctrl_d), .txd_q(txd_q)
  );

  ustat_rx_hold u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_en(ctrl_q[CT_RE]),
    .full_q(stat_q[ST_RDF]), .rx_byte(rx_byte),
    .accept(rx_accept), .overrun(rx_overrun), .buf_q(rx_buf_q)
  );

  ustat_flags u_flags (
    .clk(clk), .rst(rst), .wr_stat(wr_stat), .rd_stat(rd_stat),
    .rd_rxd(rd_rxd), .wr_txd(wr_txd), .wdata(reg_wdata),
    .rx_accept(rx_accept), .rx_overrun(rx_overrun),
    .frm_in(rx_frame_err), .par_in(rx_parity_err),
    .te_next(ctrl_d[CT_TE]), .tx_take(tx_take),
    .stat_q(stat_q), .stat_d(stat_d)
  );

  always_comb begin
    unique case (int'(reg_sel))
      SEL_FMT:  rd_mux = {4'b0, fmt_q};
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_STAT: rd_mux = stat_q;
      SEL_TXD:  rd_mux = txd_q;
      SEL_RXD:  rd_mux = rx_buf_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata    <= '0;
      irq_rx_full  <= 1'b0;
      irq_tx_empty <= 1'b0;
      irq_tx_end   <= 1'b0;
      irq_error    <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      irq_tx_empty <= stat_d[ST_TDE]  && ctrl_d[CT_TIE];
      irq_rx_full  <= stat_d[ST_RDF]  && ctrl_d[CT_RIE];
      irq_tx_end   <= stat_d[ST_TEND] && ctrl_d[CT_TEIE];
      irq_error    <= (stat_d[ST_OVR] || stat_d[ST_FRM] || stat_d[ST_PAR])
                      && ctrl_d[CT_RIE];
    end
  end

  assign tx_req         = !stat_q[ST_TDE];
  assign tx_byte        = txd_q;
  assign fmt_data7      = fmt_q.data7;
  assign fmt_parity_en  = fmt_q.par_en;
  assign fmt_parity_odd = fmt_q.par_odd;
  assign fmt_stop2      = fmt_q.stop2;
endmodule

// File: rtl/ustat_checker.sv
module ustat_checker
  import ustat_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              tx_take,
  input logic              tx_req,
  input logic [BYTE_W-1:0] stat,
  input logic [BYTE_W-1:0] ctrl,
  input logic [BYTE_W-1:0] rxbuf
);
  logic past_rst;
  always_ff @(posedge clk) begin
    past_rst <= rst;
    if (past_rst) begin
      assert_reset_value_R1: assert (stat == STAT_RESET && ctrl == '0);
    end
  end

  assert_overrun_keeps_byte_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && ctrl[CT_RE] && stat[ST_RDF]) |=> (stat[ST_OVR] && $stable(rxbuf)));

  assert_rx_disabled_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !ctrl[CT_RE]) |=> $stable(rxbuf));

  assert_tend_needs_tde_R8: assert property (@(posedge clk) disable iff (rst)
    !stat[ST_TDE] |-> !stat[ST_TEND]);

  assert_te_off_forces_R9: assert property (@(posedge clk) disable iff (rst)
    !ctrl[CT_TE] |-> (stat[ST_TDE] && stat[ST_TEND]));

  assert_take_completes_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_req && tx_take) |=> (!tx_req && stat[ST_TEND]));
endmodule

bind ustat_core ustat_checker u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .tx_take(tx_take),
  .tx_req(tx_req), .stat(stat_q), .ctrl(ctrl_q), .rxbuf(rx_buf_q)
);

// File: tb/ustat_core_bench.sv
module ustat_core_bench;
  localparam int AW = 3;
  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] reg_sel = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic rx_valid = 0, rx_frame_err = 0, rx_parity_err = 0, tx_take = 0;
  logic [7:0] rx_byte = '0, tx_byte;
  logic tx_req, fmt_data7, fmt_parity_en, fmt_parity_odd, fmt_stop2;
  logic irq_rx_full, irq_tx_empty, irq_tx_end, irq_error;
  int total = 0, fails = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  ustat_core #(.ADDR_W(AW)) u_ustat_core (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); reg_sel = AW'(a); reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); reg_sel = AW'(a); reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic push(input logic [7:0] b, input logic fe, input logic pe);
    @(negedge clk); rx_valid = 1; rx_byte = b; rx_frame_err = fe; rx_parity_err = pe;
    @(negedge clk); rx_valid = 0; rx_frame_err = 0; rx_parity_err = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(2, rv); chk("R1 status", rv, 8'h84);
    rd(1, rv); chk("R1 control", rv, 8'h00);
    rd(0, rv); chk("R1 format", rv, 8'h00);
    chk("R1 tx_req", tx_req, 0);

    // R11 format sweep
    for (int m = 0; m < 16; m++) begin
      wr(0, 8'(m));
      chk("R11 fmt outputs", {fmt_stop2, fmt_parity_odd, fmt_parity_en, fmt_data7}, m);
      rd(0, rv); chk("R11 readback", rv, m);
    end

    // R7 receive disabled
    do_reset();
    push(8'hA5, 1, 1);
    rd(2, rv); chk("R7 status unchanged", rv, 8'h84);
    rd(4, rv); chk("R7 buffer unchanged", rv, 8'h00);

    // R4 / R6 / R5
    wr(1, 8'h10);
    push(8'h5A, 0, 0);
    rd(2, rv); chk("R4 receive-full set", rv, 8'hC4);
    rd(4, rv); chk("R6 rx data", rv, 8'h5A);
    rd(2, rv); chk("R6 receive-full cleared", rv, 8'h84);
    push(8'h11, 0, 1);
    push(8'h22, 1, 0);
    rd(2, rv); chk("R5 overrun and parity flags", rv, 8'hEC);
    rd(4, rv); chk("R5 first byte kept", rv, 8'h11);

    // R2 / R3 / R8 status write sweep after read
    for (int w = 0; w < 256; w++) begin
      logic [7:0] wv, ex;
      wv = 8'(w);
      do_reset();
      wr(1, 8'h30);
      push(8'h01, 1, 1);
      push(8'h02, 0, 0);
      rd(2, rv);
      wr(2, wv);
      ex = (wv & 8'hF8) | (wv[7] ? 8'h04 : 8'h00) | {7'b0, wv[0]};
      rd(2, rv); chk("R2 R3 R8 clear after read", rv, ex);
      chk("R10 tx_req after clear", tx_req, !wv[7]);
    end

    // R2 unread flags survive
    for (int w = 0; w < 4; w++) begin
      logic [7:0] wv;
      wv = 8'(w * 85);
      do_reset();
      wr(1, 8'h30);
      push(8'h01, 1, 1);
      push(8'h02, 0, 0);
      wr(2, wv);
      rd(2, rv); chk("R2 unread preserved", rv, 8'hFC | {7'b0, wv[0]});
    end

    // R9 transmitter disabled
    do_reset();
    wr(1, 8'h10);
    rd(2, rv);
    wr(2, 8'h00);
    rd(2, rv); chk("R9 empty flags held", rv, 8'h84);
    chk("R9 no tx_req", tx_req, 0);

    // R8 / R10 transmit hand-off
    do_reset();
    wr(1, 8'h20);
    wr(3, 8'h3C);
    rd(2, rv); chk("R8 tx write clears end", rv, 8'h80);
    wr(2, 8'h00);
    chk("R10 tx_req raised", tx_req, 1);
    chk("R10 tx_byte", tx_byte, 8'h3C);
    rd(2, rv); chk("R8 both flags low", rv, 8'h00);
    @(negedge clk); tx_take = 1; @(negedge clk); tx_take = 0;
    chk("R10 tx_req dropped", tx_req, 0);
    rd(2, rv); chk("R10 flags set after take", rv, 8'h84);

    // R12 interrupt level sweep
    do_reset();
    wr(1, 8'h30);
    push(8'h01, 0, 0);
    push(8'h02, 0, 0);
    for (int e = 0; e < 8; e++) begin
      logic [7:0] cv;
      cv = 8'h30 | (e[0] ? 8'h80 : 8'h00) | (e[1] ? 8'h40 : 8'h00) | (e[2] ? 8'h04 : 8'h00);
      wr(1, cv);
      chk("R12 irq_tx_empty", irq_tx_empty, e[0]);
      chk("R12 irq_rx_full", irq_rx_full, e[1]);
      chk("R12 irq_error", irq_error, e[1]);
      chk("R12 irq_tx_end", irq_tx_end, e[2]);
    end

    // R13 arrival colliding with receive read on a full buffer
    do_reset();
    wr(1, 8'h30);
    push(8'h11, 0, 0);
    @(negedge clk); reg_sel = AW'(4); reg_rd = 1; rx_valid = 1; rx_byte = 8'h22;
    @(negedge clk); reg_rd = 0; rx_valid = 0; rv = reg_rdata;
    chk("R13 read returns old byte", rv, 8'h11);
    rd(2, rv); chk("R13 full cleared overrun set", rv, 8'hA4);
    push(8'h33, 0, 0);
    rd(4, rv); chk("R13 later arrival accepted", rv, 8'h33);

    summary();
  end
endmodule